// File: doc/BRIEF.md
# Depth-Expansion FIFO Slice

This block is one slice of a first-in first-out buffer that can be chained with identical slices to build a deeper buffer. Each slice stores `DEPTH` words of `WIDTH` bits. The slices form a ring: the active-low expansion output of each slice feeds the expansion input of the next, and the last slice feeds the first. Two tokens travel around this ring. The write token marks the only slice that accepts writes, and the read token marks the only slice that supplies reads. Writers and readers therefore see a single buffer whose capacity is the number of slices times `DEPTH`.

A slice hands on a token by pulsing its expansion output low for one cycle, after it has written or read its last physical location. Both tokens share this one line. The receiving slice works out which token has arrived from the tokens it already holds and from whether its own store is empty. It can use that token in the same cycle the pulse is seen. All slices share the write strobe, the read strobe and the write data. Their tristated read outputs share one bus. Each slice reports local active-low full and empty flags, and an external AND gate combines them into the ring's flags.

A slice whose expansion input is held low during master reset runs standalone. It keeps both tokens at all times, its pointers wrap inside its own store, and it never pulses its expansion output. Master reset is synchronous, and the mode and starting tokens are captured while it is active.

Top module: `xslice_fifo`

## Requirements
- R1: While `mr_n` is low, each slice empties its store and drives `xout_n` high. After release, a slice that holds the read token shows `empty_n` low, no slice shows `full_n` low, and `xout_n` stays high.
- R2: When `xin_n` is low during master reset, the slice runs standalone. It holds both tokens permanently, its pointers wrap from location DEPTH-1 to location 0, and `xout_n` stays high.
- R3: When `xin_n` is high during master reset, the slice joins a ring. It starts with both tokens if `first_n` is low and with neither token if `first_n` is high. A slice with no tokens shows `full_n` and `empty_n` high.
- R4: Words are read in the order they were written, across slice boundaries as well as inside one slice.
- R5: In a ring, an accepted write to physical location DEPTH-1 drops the write token. It also drives `xout_n` low for exactly the following cycle. In any other cycle `xout_n` is high.
- R6: In a ring, an accepted read of physical location DEPTH-1 drops the read token and drives `xout_n` low for the following cycle.
- R7: A low cycle on `xin_n` delivers the read token to a slice that holds only the write token. It delivers the write token to a slice that holds only the read token. A slice holding neither token takes the write token if its store is empty and the read token otherwise. The token can be used in that same cycle.
- R8: A write (`wr_n` low at a rising edge) is stored only by the slice holding the write token, and only if that slice's store is not full. A slice holding the write token with all DEPTH locations used shows `full_n` low and refuses the write, even if a read happens in the same cycle.
- R9: A read (`rd_n` low at a rising edge) removes a word only in the slice holding the read token, and only if its store is not empty. `rdata` carries that slice's oldest word while `rd_n` is low; every other slice leaves `rdata` at high impedance.
- R10: The AND of all slices' `full_n` goes low exactly when the ring holds (number of slices × DEPTH) words. The AND of all `empty_n` goes low exactly when the ring holds no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Synchronous master reset, active low |
| first_n | input | 1 | Low marks the slice that is loaded first in a ring |
| xin_n | input | 1 | Expansion input from the previous slice; tie low for standalone use |
| xout_n | output | 1 | Expansion output, one-cycle low pulse per token handed on |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | WIDTH | Write data |
| rd_n | input | 1 | Read strobe, active low |
| rdata | output | WIDTH | Read data, high impedance unless this slice is serving a read |
| full_n | output | 1 | Low when this slice holds the write token and its store is full |
| empty_n | output | 1 | Low when this slice holds the read token and its store is empty |

## Verification
The bench builds a ring of three slices with WIDTH 9 and DEPTH 4. With this depth, every token changes hands after only four words, and the ring's combined capacity of 12 is reached within a short table. Both tokens lap the ring, and a slice must receive the write token again while it still holds unread data. The bench also builds one standalone slice with DEPTH 3, which selects the pointer-wrap variant for a depth that is not a power of two.

// File: rtl/xslice_pkg.sv
package xslice_pkg;

   typedef enum logic {
      MODE_SOLO = 1'b0,
      MODE_RING = 1'b1
   } slice_mode_e;

   typedef struct packed {
      logic wr;
      logic rd;
   } tok_s;

   // Which token a low cycle on the expansion input hands over.
   function automatic tok_s arriving_token(tok_s held, logic store_empty);
      tok_s got;
      got = '0;
      if (held.wr && !held.rd) begin
         got.rd = 1'b1;
      end else if (held.rd && !held.wr) begin
         got.wr = 1'b1;
      end else if (!held.wr && !held.rd) begin
         if (store_empty) got.wr = 1'b1;
         else             got.rd = 1'b1;
      end
      return got;
   endfunction

endpackage

// File: rtl/xslice_store.sv
module xslice_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             mr_n,
   input  logic             wr_go,
   input  logic             rd_go,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    fill,
   output logic             wr_end,
   output logic             rd_end
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr;
   logic [AW-1:0]    rptr;
   logic [AW-1:0]    wptr_nx;
   logic [AW-1:0]    rptr_nx;

   generate
      if ((1 << AW) == DEPTH) begin : g_wrap_pow2
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_go) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!mr_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (wr_go) wptr <= wptr_nx;
         if (rd_go) rptr <= rptr_nx;
         if (wr_go && !rd_go)      fill <= fill + 1'b1;
         else if (!wr_go && rd_go) fill <= fill - 1'b1;
      end
   end

   assign head   = mem[rptr];
   assign wr_end = wr_go && (wptr == LAST);
   assign rd_end = rd_go && (rptr == LAST);

endmodule

// File: rtl/xslice_token.sv
module xslice_token
   import xslice_pkg::*;
(
   input  logic        clk,
   input  logic        mr_n,
   input  logic        first_n,
   input  logic        xin_n,
   input  logic        wr_end,
   input  logic        rd_end,
   input  logic        store_empty,
   output slice_mode_e mode,
   output tok_s        hold,
   output logic        xout_n
);

   tok_s        tok_q;
   tok_s        arrive;
   slice_mode_e mode_q;

   always_comb begin
      arrive = '0;
      if (mode_q == MODE_RING && !xin_n) arrive = arriving_token(tok_q, store_empty);
   end

   assign hold = tok_s'(tok_q | arrive);
   assign mode = mode_q;

   always_ff @(posedge clk) begin
      if (!mr_n) begin
         mode_q <= xin_n ? MODE_RING : MODE_SOLO;
         tok_q  <= (!xin_n || !first_n) ? tok_s'(2'b11) : tok_s'(2'b00);
         xout_n <= 1'b1;
      end else if (mode_q == MODE_RING) begin
         tok_q.wr <= hold.wr & ~wr_end;
         tok_q.rd <= hold.rd & ~rd_end;
         xout_n   <= ~(wr_end | rd_end);
      end else begin
         xout_n <= 1'b1;
      end
   end

endmodule

// File: rtl/xslice_fifo.sv
module xslice_fifo
   import xslice_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             mr_n,
   input  logic             first_n,
   input  logic             xin_n,
   output logic             xout_n,
   input  logic             wr_n,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_n,
   output wire  [WIDTH-1:0] rdata,
   output logic             full_n,
   output logic             empty_n
);

   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || WIDTH < 1) begin : g_bad_params
         initial $fatal(1, "xslice_fifo: DEPTH must be at least 2 and WIDTH at least 1");
      end
   endgenerate

   slice_mode_e      mode;
   tok_s             hold;
   logic [WIDTH-1:0] head;
   logic [CW-1:0]    fill;
   logic             wr_go;
   logic             rd_go;
   logic             wr_end;
   logic             rd_end;
   logic             st_full;
   logic             st_empty;
   logic             hold_wr;
   logic             hold_rd;
   logic             mode_ring;

   assign st_full   = (fill == CW'(DEPTH));
   assign st_empty  = (fill == '0);
   assign hold_wr   = hold.wr;
   assign hold_rd   = hold.rd;
   assign mode_ring = (mode == MODE_RING);

   assign wr_go = hold_wr && !wr_n && !st_full;
   assign rd_go = hold_rd && !rd_n && !st_empty;

   xslice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .mr_n   (mr_n),
      .wr_go  (wr_go),
      .rd_go  (rd_go),
      .wdata  (wdata),
      .head   (head),
      .fill   (fill),
      .wr_end (wr_end),
      .rd_end (rd_end)
   );

   xslice_token u_tok (
      .clk         (clk),
      .mr_n        (mr_n),
      .first_n     (first_n),
      .xin_n       (xin_n),
      .wr_end      (wr_end),
      .rd_end      (rd_end),
      .store_empty (st_empty),
      .mode        (mode),
      .hold        (hold),
      .xout_n      (xout_n)
   );

   assign full_n  = ~(hold_wr & st_full);
   assign empty_n = ~(hold_rd & st_empty);
   assign rdata   = rd_go ? head : {WIDTH{1'bz}};

endmodule

// File: rtl/xslice_fifo_chk.sv
module xslice_fifo_chk #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          mr_n,
   input logic          wr_n,
   input logic          rd_n,
   input logic          xout_n,
   input logic          full_n,
   input logic          empty_n,
   input logic          mode_ring,
   input logic          hold_wr,
   input logic          hold_rd,
   input logic [CW-1:0] fill,
   input logic          wr_end,
   input logic          rd_end
);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!mr_n)
      $rose(mr_n) |-> (fill == '0 && xout_n && full_n)); // R1

   AST_SOLO_SILENT: assert property (@(posedge clk) disable iff (!mr_n)
      !mode_ring |-> (xout_n && hold_wr && hold_rd)); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
      fill <= CW'(DEPTH)); // R8

   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!mr_n)
      (!full_n && rd_n) |=> (fill == CW'(DEPTH))); // R8

   AST_EMPTY_REFUSES: assert property (@(posedge clk) disable iff (!mr_n)
      (!empty_n && wr_n) |=> (fill == '0)); // R9

   AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (!mr_n)
      (mode_ring && wr_end) |=> (!xout_n && !hold_wr)); // R5

   AST_RD_HANDOFF: assert property (@(posedge clk) disable iff (!mr_n)
      (mode_ring && rd_end) |=> (!xout_n && !hold_rd)); // R6

   AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!mr_n)
      (!wr_end && !rd_end) |=> xout_n); // R5

   AST_ENDS_APART: assert property (@(posedge clk) disable iff (!mr_n)
      !(wr_end && rd_end)); // R8

endmodule

bind xslice_fifo xslice_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .mr_n      (mr_n),
   .wr_n      (wr_n),
   .rd_n      (rd_n),
   .xout_n    (xout_n),
   .full_n    (full_n),
   .empty_n   (empty_n),
   .mode_ring (mode_ring),
   .hold_wr   (hold_wr),
   .hold_rd   (hold_rd),
   .fill      (fill),
   .wr_end    (wr_end),
   .rd_end    (rd_end)
);

// File: tb/test_xslice_fifo.sv
`timescale 1ns/1ps
module test_xslice_fifo;

   localparam int W    = 9;
   localparam int D    = 4;
   localparam int CAP  = 3 * D;
   localparam int SD   = 3;
   localparam int NVEC = 28;

   // {write, read, data}
   localparam logic [10:0] VEC [NVEC] = '{
      {2'b10, 9'h010}, {2'b10, 9'h011}, {2'b10, 9'h012}, {2'b10, 9'h013},
      {2'b10, 9'h014}, {2'b10, 9'h015}, {2'b10, 9'h016}, {2'b10, 9'h017},
      {2'b10, 9'h018}, {2'b10, 9'h019}, {2'b10, 9'h01A}, {2'b10, 9'h01B},
      {2'b10, 9'h0EE},                   // R8 refused: ring full
      {2'b11, 9'h0AA},                   // R8 refused while a read frees a slot
      {2'b11, 9'h0BB},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000},
      {2'b01, 9'h000},                   // R9 refused: ring empty
      {2'b10, 9'h0CC}
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         mr_n  = 1'b0;
   logic         wr_n  = 1'b1;
   logic         rd_n  = 1'b1;
   logic [W-1:0] wdata = '0;
   wire  [W-1:0] ring_q;
   logic         xo0, xo1, xo2;
   logic         f0, f1, f2, e0, e1, e2;

   logic         s_wr_n  = 1'b1;
   logic         s_rd_n  = 1'b1;
   logic [W-1:0] s_wdata = '0;
   wire  [W-1:0] s_q;
   logic         s_xo, s_full_n, s_empty_n;

   xslice_fifo #(.WIDTH(W), .DEPTH(D)) i_xslice_fifo (
      .clk(clk), .mr_n(mr_n), .first_n(1'b0), .xin_n(xo2), .xout_n(xo0),
      .wr_n(wr_n), .wdata(wdata), .rd_n(rd_n), .rdata(ring_q),
      .full_n(f0), .empty_n(e0));

   xslice_fifo #(.WIDTH(W), .DEPTH(D)) i_xslice_fifo_1 (
      .clk(clk), .mr_n(mr_n), .first_n(1'b1), .xin_n(xo0), .xout_n(xo1),
      .wr_n(wr_n), .wdata(wdata), .rd_n(rd_n), .rdata(ring_q),
      .full_n(f1), .empty_n(e1));

   xslice_fifo #(.WIDTH(W), .DEPTH(D)) i_xslice_fifo_2 (
      .clk(clk), .mr_n(mr_n), .first_n(1'b1), .xin_n(xo1), .xout_n(xo2),
      .wr_n(wr_n), .wdata(wdata), .rd_n(rd_n), .rdata(ring_q),
      .full_n(f2), .empty_n(e2));

   xslice_fifo #(.WIDTH(W), .DEPTH(SD)) i_xslice_fifo_solo (
      .clk(clk), .mr_n(mr_n), .first_n(1'b1), .xin_n(1'b0), .xout_n(s_xo),
      .wr_n(s_wr_n), .wdata(s_wdata), .rd_n(s_rd_n), .rdata(s_q),
      .full_n(s_full_n), .empty_n(s_empty_n));

   wire all_full_n  = f0 & f1 & f2;
   wire all_empty_n = e0 & e1 & e2;

   int checks = 0;
   int errors = 0;
   int rq[$];
   int sq[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // One ring cycle: drive at the falling edge, check the combined outputs,
   // then update the reference queue at the rising edge.
   task automatic ring_step(input bit w, input bit r, input logic [W-1:0] d, input string tag);
      bit wr_ok, rd_ok;
      @(negedge clk);
      wr_n  = ~w;
      rd_n  = ~r;
      wdata = d;
      #1;
      chk(all_full_n === (rq.size() != CAP), {tag, " R10 ring full"}, int'(all_full_n), int'(rq.size() != CAP));
      chk(all_empty_n === (rq.size() != 0), {tag, " R10 ring empty"}, int'(all_empty_n), int'(rq.size() != 0));
      if (r && rq.size() > 0)
         chk(ring_q === W'(rq[0]), {tag, " R4 R9 read word"}, int'(ring_q), rq[0]);
      wr_ok = w && (rq.size() < CAP);
      rd_ok = r && (rq.size() > 0);
      @(posedge clk);
      if (rd_ok) void'(rq.pop_front());
      if (wr_ok) rq.push_back(int'(d));
   endtask

   task automatic solo_step(input bit w, input bit r, input logic [W-1:0] d);
      bit wr_ok, rd_ok;
      @(negedge clk);
      s_wr_n  = ~w;
      s_rd_n  = ~r;
      s_wdata = d;
      #1;
      chk(s_xo === 1'b1, "R2 standalone xout_n high", int'(s_xo), 1);
      chk(s_full_n === (sq.size() != SD), "R2 R8 standalone full_n", int'(s_full_n), int'(sq.size() != SD));
      chk(s_empty_n === (sq.size() != 0), "R2 R9 standalone empty_n", int'(s_empty_n), int'(sq.size() != 0));
      if (r && sq.size() > 0)
         chk(s_q === W'(sq[0]), "R2 R4 standalone wrap order", int'(s_q), sq[0]);
      wr_ok = w && (sq.size() < SD);
      rd_ok = r && (sq.size() > 0);
      @(posedge clk);
      if (rd_ok) void'(sq.pop_front());
      if (wr_ok) sq.push_back(int'(d));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      mr_n = 1'b1;
      #1;
      // R1 / R3: state after master reset
      chk(e0 === 1'b0, "R1 first slice empty_n", int'(e0), 0);
      chk(e1 === 1'b1 && e2 === 1'b1, "R3 tokenless empty_n high", int'({e1, e2}), 3);
      chk({f0, f1, f2} === 3'b111, "R1 R3 full_n high", int'({f0, f1, f2}), 7);
      chk({xo0, xo1, xo2} === 3'b111, "R1 xout_n high", int'({xo0, xo1, xo2}), 7);

      ring_step(1'b0, 1'b1, '0, "R9 read at empty");
      ring_step(1'b1, 1'b0, 9'h101, "R3 first slice write");
      ring_step(1'b1, 1'b0, 9'h102, "R4");
      ring_step(1'b1, 1'b0, 9'h103, "R4");
      ring_step(1'b1, 1'b0, 9'h104, "R5 last location");
      #1;
      chk(xo0 === 1'b0, "R5 pulse after last write", int'(xo0), 0);
      chk(xo1 === 1'b1, "R5 next slice quiet", int'(xo1), 1);
      ring_step(1'b1, 1'b0, 9'h105, "R7 write taken same cycle");
      #1;
      chk(xo0 === 1'b1, "R5 pulse lasts one cycle", int'(xo0), 1);
      ring_step(1'b0, 1'b1, '0, "R4");
      ring_step(1'b0, 1'b1, '0, "R4");
      ring_step(1'b0, 1'b1, '0, "R4");
      ring_step(1'b0, 1'b1, '0, "R6 last location read");
      #1;
      chk(xo0 === 1'b0, "R6 pulse after last read", int'(xo0), 0);
      ring_step(1'b0, 1'b1, '0, "R7 read token taken same cycle");
      ring_step(1'b0, 1'b0, '0, "R10 idle");

      for (int i = 0; i < NVEC; i++)
         ring_step(VEC[i][10], VEC[i][9], VEC[i][8:0], "table R8 R9");
      for (int i = 0; i < 2; i++)
         ring_step(1'b0, 1'b1, '0, "drain R4");

      // R2: standalone slice of depth 3
      solo_step(1'b1, 1'b0, 9'h1A0);
      solo_step(1'b1, 1'b0, 9'h1A1);
      solo_step(1'b1, 1'b0, 9'h1A2);
      solo_step(1'b1, 1'b0, 9'h1A3);   // R8 refused: full
      solo_step(1'b0, 1'b1, '0);
      solo_step(1'b0, 1'b1, '0);
      solo_step(1'b1, 1'b0, 9'h1B0);
      solo_step(1'b1, 1'b0, 9'h1B1);
      solo_step(1'b0, 1'b1, '0);
      solo_step(1'b0, 1'b1, '0);
      solo_step(1'b0, 1'b1, '0);
      solo_step(1'b0, 1'b1, '0);       // R9 refused: empty
      solo_step(1'b0, 1'b0, '0);

      finish_run();
   end

endmodule